// File: doc/BRIEF.md
# Security Tag Propagation Unit

This block sits beside the execution datapath of a simple processor and computes security tags in step with each instruction. Every word carries a tag made of a sensitivity level and a compartment mask. For each issued instruction the unit combines the operand tags, the instruction tag and the tag held for the program counter. It produces the tag of the result and the next program-counter tag. Where a transfer would let information reach a context that may not hold it, it raises a trap with a cause code instead.

The program-counter tag carries the context of values that control flow has depended on. A conditional branch saves the current program-counter tag on a small internal stack and raises the tag by the branch condition's tag. The matching rejoin instruction restores the saved tag. Memory reads and channel transfers are checked against the principal register, which holds the privileges of the running process. The trap handler, the ALU and the register file lie outside this block.

Top module: `tagflow_unit`

## Requirements
- R1: A tag is {level, compartments}: the level is in bits [TAG_W-1:CMP_W] and the compartment mask in bits [CMP_W-1:0]. The join of tags is the maximum level together with the OR of the masks. Tag X may flow to Y when X's level is at most Y's and X's mask has no bit outside Y's. Instruction classes on `class_i` are: 0 compute, 1 jump, 2 conditional branch, 3 rejoin, 4 load, 5 channel input, 6 channel output, 7 reserved. A compute instruction (class 0) issued with `valid_i` high sets `res_tag_o` to the join of both operand tags, the PC tag and the instruction tag, with `res_valid_o` high one cycle later.
- R2: For every non-trapping instruction of classes 0, 1, 4, 5 and 6, the next PC tag is the join of the old PC tag and the instruction tag. A jump produces no result (`res_valid_o` low).
- R3: A conditional branch (class 2) pushes the current PC tag and sets the PC tag to the join of operand A's tag, the PC tag and the instruction tag. It produces no result.
- R4: A rejoin (class 3) pops the stack and sets the PC tag to the popped value, in last-in first-out order across nested branches.
- R5: A load (class 4) traps with cause 1 unless operand A's tag may flow to the principal. Otherwise its result tag is the join of A's tag, the PC tag and the instruction tag.
- R6: A channel input (class 5) traps with cause 2 unless the channel tag may flow to the principal. Otherwise its result tag equals the channel tag.
- R7: A channel output (class 6) traps with cause 3 unless operand A's tag may flow to the channel tag. It produces no result.
- R8: A conditional branch with STK_DEPTH entries already saved traps with cause 4. A rejoin with an empty stack traps with cause 5.
- R9: On a trap, `trap_o` is high for one cycle with the cause on `trap_cause_o`. In that cycle `res_tag_o` and `pc_tag_o` keep their values, `res_valid_o` is low, and the stack is untouched.
- R10: After reset all tags are zero, `trap_o` and `res_valid_o` are low and the cause is 0. A cycle without `valid_i` changes no tag and raises no trap.
- R11: Class 7 traps with cause 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| valid_i | input | 1 | An instruction is issued this cycle |
| class_i | input | 3 | Instruction class |
| opa_tag_i | input | TAG_W | Tag of operand A (read datum, branch condition, output datum) |
| opb_tag_i | input | TAG_W | Tag of operand B |
| insn_tag_i | input | TAG_W | Tag of the instruction word |
| principal_i | input | TAG_W | Principal register of the running process |
| chan_tag_i | input | TAG_W | Tag of the I/O channel addressed |
| res_tag_o | output | TAG_W | Tag of the latest result |
| res_valid_o | output | 1 | res_tag_o was written by the previous instruction |
| pc_tag_o | output | TAG_W | Current program-counter tag |
| trap_o | output | 1 | Previous instruction trapped |
| trap_cause_o | output | 3 | Trap cause, 0 when no trap |

## Verification
The join is tried with operands that differ only in level, only in compartments, and in both. A result that took the maximum of the levels but dropped a mask bit, or the reverse, is therefore caught. Nested branches with distinct condition tags, followed by rejoins, separate true last-in first-out restoring from a stack that returns the wrong entry or simply keeps the raised tag. Each of the three flow checks is driven once with a permitted tag pair and once with a pair that fails only on a compartment or only on a level. The stack is filled to its exact depth and drained to empty before the over- and under-run instructions, so an off-by-one in the limits shows up.

// File: rtl/tagflow_pkg.sv
package tagflow_pkg;

   typedef enum logic [2:0] {
      CLS_ALU    = 3'd0,
      CLS_JUMP   = 3'd1,
      CLS_CBR    = 3'd2,
      CLS_REJOIN = 3'd3,
      CLS_LOAD   = 3'd4,
      CLS_CHIN   = 3'd5,
      CLS_CHOUT  = 3'd6,
      CLS_RSVD   = 3'd7
   } insn_class_e;

   typedef enum logic [2:0] {
      TRAP_NONE  = 3'd0,
      TRAP_READ  = 3'd1,
      TRAP_CHIN  = 3'd2,
      TRAP_CHOUT = 3'd3,
      TRAP_OVF   = 3'd4,
      TRAP_UNF   = 3'd5,
      TRAP_CLASS = 3'd6
   } trap_cause_e;

endpackage

// File: rtl/tf_join.sv
// Least upper bound of N packed tags: max level, OR of compartments.
module tf_join #(
   parameter int N     = 2,
   parameter int LVL_W = 3,
   parameter int CMP_W = 8,
   localparam int TAG_W = LVL_W + CMP_W
) (
   input  logic [N*TAG_W-1:0] tags_i,
   output logic [TAG_W-1:0]   tag_o
);

   if (N < 2) begin : g_bad_n
      $error("tf_join needs at least two inputs");
   end

   logic [LVL_W-1:0] lvl;
   logic [LVL_W-1:0] lk;
   logic [CMP_W-1:0] cmp;

   always_comb begin
      lvl = '0;
      cmp = '0;
      lk  = '0;
      for (int k = 0; k < N; k++) begin
         lk = tags_i[k*TAG_W+CMP_W +: LVL_W];
         if (lk > lvl) lvl = lk;
         cmp = cmp | tags_i[k*TAG_W +: CMP_W];
      end
      tag_o = {lvl, cmp};
   end

endmodule

// File: rtl/tf_flow.sv
// Flow permission: source level <= destination level and source
// compartments contained in destination compartments.
module tf_flow #(
   parameter int LVL_W = 3,
   parameter int CMP_W = 8,
   localparam int TAG_W = LVL_W + CMP_W
) (
   input  logic [TAG_W-1:0] src_i,
   input  logic [TAG_W-1:0] dst_i,
   output logic             ok_o
);

   logic lvl_ok;
   logic cmp_ok;

   assign lvl_ok = src_i[TAG_W-1:CMP_W] <= dst_i[TAG_W-1:CMP_W];
   assign cmp_ok = (src_i[CMP_W-1:0] & ~dst_i[CMP_W-1:0]) == '0;
   assign ok_o   = lvl_ok && cmp_ok;

endmodule

// File: rtl/tf_tag_stack.sv
// Fixed-depth LIFO of saved program-counter tags.
module tf_tag_stack #(
   parameter int DEPTH = 8,
   parameter int TAG_W = 11,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic [TAG_W-1:0] data_i,
   output logic [TAG_W-1:0] top_o,
   output logic             full_o,
   output logic             empty_o
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("tf_tag_stack depth must be at least one");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [TAG_W-1:0] ent_q [DEPTH];

   assign full_o  = cnt_q == CNT_W'(DEPTH);
   assign empty_o = cnt_q == '0;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent_q[e] <= '0;
         else if (push_i && !full_o && cnt_q == CNT_W'(e))
            ent_q[e] <= data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (push_i && !full_o)
         cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !empty_o)
         cnt_q <= cnt_q - 1'b1;
   end

   always_comb begin
      top_o = '0;
      for (int e = 0; e < DEPTH; e++) begin
         if (cnt_q == CNT_W'(e + 1)) top_o = ent_q[e];
      end
   end

endmodule

// File: rtl/tagflow_unit.sv
module tagflow_unit
   import tagflow_pkg::*;
#(
   parameter int LVL_W     = 3,
   parameter int CMP_W     = 8,
   parameter int STK_DEPTH = 8,
   localparam int TAG_W    = LVL_W + CMP_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic [2:0]       class_i,
   input  logic [TAG_W-1:0] opa_tag_i,
   input  logic [TAG_W-1:0] opb_tag_i,
   input  logic [TAG_W-1:0] insn_tag_i,
   input  logic [TAG_W-1:0] principal_i,
   input  logic [TAG_W-1:0] chan_tag_i,
   output logic [TAG_W-1:0] res_tag_o,
   output logic             res_valid_o,
   output logic [TAG_W-1:0] pc_tag_o,
   output logic             trap_o,
   output logic [2:0]       trap_cause_o
);

   if (LVL_W < 1 || CMP_W < 1) begin : g_bad_width
      $error("tagflow_unit: level and compartment widths must be positive");
   end
   if (STK_DEPTH < 1) begin : g_bad_stack
      $error("tagflow_unit: PC tag stack needs at least one entry");
   end

   logic [TAG_W-1:0] pc_q, res_q;
   logic             res_v_q, trap_q;
   trap_cause_e      cause_q;

   // joined tags shared by several classes
   logic [TAG_W-1:0] join4, join3, join2;

   tf_join #(.N(4), .LVL_W(LVL_W), .CMP_W(CMP_W)) u_join4 (
      .tags_i ({opa_tag_i, opb_tag_i, pc_q, insn_tag_i}),
      .tag_o  (join4)
   );
   tf_join #(.N(3), .LVL_W(LVL_W), .CMP_W(CMP_W)) u_join3 (
      .tags_i ({opa_tag_i, pc_q, insn_tag_i}),
      .tag_o  (join3)
   );
   tf_join #(.N(2), .LVL_W(LVL_W), .CMP_W(CMP_W)) u_join2 (
      .tags_i ({pc_q, insn_tag_i}),
      .tag_o  (join2)
   );

   // flow permissions
   logic rd_ok, in_ok, out_ok;

   tf_flow #(.LVL_W(LVL_W), .CMP_W(CMP_W)) u_flow_rd (
      .src_i (opa_tag_i), .dst_i (principal_i), .ok_o (rd_ok)
   );
   tf_flow #(.LVL_W(LVL_W), .CMP_W(CMP_W)) u_flow_in (
      .src_i (chan_tag_i), .dst_i (principal_i), .ok_o (in_ok)
   );
   tf_flow #(.LVL_W(LVL_W), .CMP_W(CMP_W)) u_flow_out (
      .src_i (opa_tag_i), .dst_i (chan_tag_i), .ok_o (out_ok)
   );

   // saved PC tags
   logic             stk_push, stk_pop, stk_full, stk_empty;
   logic [TAG_W-1:0] stk_top;

   tf_tag_stack #(.DEPTH(STK_DEPTH), .TAG_W(TAG_W)) u_stack (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (stk_push),
      .pop_i   (stk_pop),
      .data_i  (pc_q),
      .top_o   (stk_top),
      .full_o  (stk_full),
      .empty_o (stk_empty)
   );

   // per-class decode
   insn_class_e      cls;
   trap_cause_e      cause_d;
   logic [TAG_W-1:0] res_d, pc_d;
   logic             res_we;

   assign cls = insn_class_e'(class_i);

   always_comb begin
      cause_d = TRAP_NONE;
      res_d   = res_q;
      res_we  = 1'b0;
      pc_d    = join2;
      unique case (cls)
         CLS_ALU: begin
            res_d  = join4;
            res_we = 1'b1;
         end
         CLS_JUMP: ;
         CLS_CBR: begin
            pc_d = join3;
            if (stk_full) cause_d = TRAP_OVF;
         end
         CLS_REJOIN: begin
            pc_d = stk_top;
            if (stk_empty) cause_d = TRAP_UNF;
         end
         CLS_LOAD: begin
            res_d  = join3;
            res_we = 1'b1;
            if (!rd_ok) cause_d = TRAP_READ;
         end
         CLS_CHIN: begin
            res_d  = chan_tag_i;
            res_we = 1'b1;
            if (!in_ok) cause_d = TRAP_CHIN;
         end
         CLS_CHOUT: begin
            if (!out_ok) cause_d = TRAP_CHOUT;
         end
         default: cause_d = TRAP_CLASS;
      endcase
   end

   logic commit;
   assign commit   = valid_i && (cause_d == TRAP_NONE);
   assign stk_push = commit && (cls == CLS_CBR);
   assign stk_pop  = commit && (cls == CLS_REJOIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= '0;
         res_q   <= '0;
         res_v_q <= 1'b0;
         trap_q  <= 1'b0;
         cause_q <= TRAP_NONE;
      end else begin
         res_v_q <= commit && res_we;
         trap_q  <= valid_i && (cause_d != TRAP_NONE);
         cause_q <= valid_i ? cause_d : TRAP_NONE;
         if (commit) begin
            pc_q <= pc_d;
            if (res_we) res_q <= res_d;
         end
      end
   end

   assign res_tag_o    = res_q;
   assign res_valid_o  = res_v_q;
   assign pc_tag_o     = pc_q;
   assign trap_o       = trap_q;
   assign trap_cause_o = cause_q;

endmodule

// File: rtl/tagflow_chk.sv
module tagflow_chk #(
   parameter int LVL_W = 3,
   parameter int CMP_W = 8,
   localparam int TAG_W = LVL_W + CMP_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             valid_i,
   input logic [2:0]       class_i,
   input logic [TAG_W-1:0] opa_tag_i,
   input logic [TAG_W-1:0] principal_i,
   input logic [TAG_W-1:0] chan_tag_i,
   input logic [TAG_W-1:0] res_tag_o,
   input logic             res_valid_o,
   input logic [TAG_W-1:0] pc_tag_o,
   input logic             trap_o
);

   function automatic logic may_flow(input logic [TAG_W-1:0] s, input logic [TAG_W-1:0] d);
      return (s[TAG_W-1:CMP_W] <= d[TAG_W-1:CMP_W]) &&
             ((s[CMP_W-1:0] & ~d[CMP_W-1:0]) == '0);
   endfunction

   logic seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= 1'b1;
   end

   // R9: trap freezes both tags and suppresses the result strobe
   p_trap_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && trap_o) |-> (pc_tag_o == $past(pc_tag_o) &&
                              res_tag_o == $past(res_tag_o) && !res_valid_o));

   // R9: trap and result strobe never together
   p_trap_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(trap_o && res_valid_o));

   // R2: outside a rejoin the PC tag only rises in the lattice
   p_pc_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && $past(class_i) != 3'd3 && !trap_o) |->
      may_flow($past(pc_tag_o), pc_tag_o));

   // R5: a completed load had a permitted read
   p_read_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && res_valid_o && $past(class_i) == 3'd4) |->
      may_flow($past(opa_tag_i), $past(principal_i)));

   // R6: channel input takes the channel tag
   p_chin_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && res_valid_o && $past(class_i) == 3'd5) |->
      res_tag_o == $past(chan_tag_i));

   // R7: a completed channel output had a permitted flow
   p_out_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && $past(valid_i) && $past(class_i) == 3'd6 && !trap_o) |->
      may_flow($past(opa_tag_i), $past(chan_tag_i)));

endmodule

bind tagflow_unit tagflow_chk #(.LVL_W(LVL_W), .CMP_W(CMP_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .valid_i     (valid_i),
   .class_i     (class_i),
   .opa_tag_i   (opa_tag_i),
   .principal_i (principal_i),
   .chan_tag_i  (chan_tag_i),
   .res_tag_o   (res_tag_o),
   .res_valid_o (res_valid_o),
   .pc_tag_o    (pc_tag_o),
   .trap_o      (trap_o)
);

// File: tb/tb_tagflow_unit.sv
module tb_tagflow_unit;

   localparam int CLK_PERIOD = 10;
   localparam int LW = 3;
   localparam int CW = 8;
   localparam int TW = LW + CW;
   localparam int DEPTH = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          valid_i = 1'b0;
   logic [2:0]    class_i = '0;
   logic [TW-1:0] opa_tag_i = '0, opb_tag_i = '0, insn_tag_i = '0;
   logic [TW-1:0] principal_i = '0, chan_tag_i = '0;
   logic [TW-1:0] res_tag_o, pc_tag_o;
   logic          res_valid_o, trap_o;
   logic [2:0]    trap_cause_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   tagflow_unit #(.LVL_W(LW), .CMP_W(CW), .STK_DEPTH(DEPTH)) dut (.*);

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench-side model state
   logic [TW-1:0] m_pc = '0, m_res = '0;
   logic [TW-1:0] m_stk [DEPTH];
   int            m_cnt = 0;

   function automatic logic [TW-1:0] mk(input int l, input int c);
      return {LW'(l), CW'(c)};
   endfunction

   function automatic logic [TW-1:0] lub(input logic [TW-1:0] x, input logic [TW-1:0] y);
      logic [LW-1:0] l;
      l = (x[TW-1:CW] > y[TW-1:CW]) ? x[TW-1:CW] : y[TW-1:CW];
      return {l, x[CW-1:0] | y[CW-1:0]};
   endfunction

   function automatic bit flows(input logic [TW-1:0] s, input logic [TW-1:0] d);
      return (s[TW-1:CW] <= d[TW-1:CW]) && ((s[CW-1:0] & ~d[CW-1:0]) == '0);
   endfunction

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // issue one instruction, predict from the requirements, compare all outputs
   task automatic run(input logic [2:0] cls, input logic [TW-1:0] a, input logic [TW-1:0] b,
                      input logic [TW-1:0] ins, input logic [TW-1:0] prin,
                      input logic [TW-1:0] chan, input string rq);
      logic [2:0]    cause;
      logic [TW-1:0] npc, nres;
      bit            rv, psh, pp;
      cause = 3'd0; npc = lub(m_pc, ins); nres = m_res; rv = 0; psh = 0; pp = 0;
      case (cls)
         3'd0: begin nres = lub(lub(a, b), lub(m_pc, ins)); rv = 1; end
         3'd1: ;
         3'd2: begin npc = lub(a, lub(m_pc, ins)); if (m_cnt == DEPTH) cause = 3'd4; else psh = 1; end
         3'd3: begin if (m_cnt == 0) cause = 3'd5; else begin npc = m_stk[m_cnt-1]; pp = 1; end end
         3'd4: begin nres = lub(a, lub(m_pc, ins)); rv = 1; if (!flows(a, prin)) cause = 3'd1; end
         3'd5: begin nres = chan; rv = 1; if (!flows(chan, prin)) cause = 3'd2; end
         3'd6: begin if (!flows(a, chan)) cause = 3'd3; end
         default: cause = 3'd6;
      endcase
      if (cause != 0) begin
         npc = m_pc; nres = m_res; rv = 0; psh = 0; pp = 0;
      end
      @(negedge clk);
      class_i = cls; opa_tag_i = a; opb_tag_i = b; insn_tag_i = ins;
      principal_i = prin; chan_tag_i = chan; valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
      chk(rq, "trap", 32'(trap_o), 32'(cause != 0));
      chk(rq, "cause", 32'(trap_cause_o), 32'(cause));
      chk(rq, "res_valid", 32'(res_valid_o), 32'(rv));
      chk(rq, "res_tag", 32'(res_tag_o), 32'(nres));
      chk(rq, "pc_tag", 32'(pc_tag_o), 32'(npc));
      if (psh) begin m_stk[m_cnt] = m_pc; m_cnt++; end
      if (pp) m_cnt--;
      m_pc = npc; m_res = nres;
   endtask

   task automatic t_reset();
      chk("R10", "reset pc", 32'(pc_tag_o), 0);
      chk("R10", "reset res", 32'(res_tag_o), 0);
      chk("R10", "reset trap", 32'(trap_o), 0);
      chk("R10", "reset cause", 32'(trap_cause_o), 0);
      chk("R10", "reset res_valid", 32'(res_valid_o), 0);
   endtask

   task automatic t_compute();
      // levels differ, masks disjoint
      run(3'd0, mk(2, 8'h03), mk(1, 8'h10), mk(0, 8'h80), '0, '0, "R1");
      // same level, overlapping masks
      run(3'd0, mk(3, 8'h0C), mk(3, 8'h06), mk(1, 8'h00), '0, '0, "R1");
      // level only from operand B
      run(3'd0, mk(0, 8'h00), mk(6, 8'h00), mk(0, 8'h01), '0, '0, "R1");
      run(3'd1, '0, '0, mk(4, 8'h20), '0, '0, "R2");
   endtask

   task automatic t_idle();
      logic [TW-1:0] p, r;
      p = pc_tag_o; r = res_tag_o;
      @(negedge clk);
      class_i = 3'd7; opa_tag_i = '1; valid_i = 1'b0;
      @(negedge clk);
      chk("R10", "idle trap", 32'(trap_o), 0);
      chk("R10", "idle res_valid", 32'(res_valid_o), 0);
      chk("R10", "idle pc", 32'(pc_tag_o), 32'(p));
      chk("R10", "idle res", 32'(res_tag_o), 32'(r));
   endtask

   task automatic t_nested();
      run(3'd2, mk(5, 8'h01), '0, mk(0, 8'h00), '0, '0, "R3");
      run(3'd2, mk(1, 8'h40), '0, mk(2, 8'h02), '0, '0, "R3");
      run(3'd0, mk(1, 8'h00), mk(0, 8'h00), '0, '0, '0, "R1");
      run(3'd3, '0, '0, '0, '0, '0, "R4");
      run(3'd3, '0, '0, '0, '0, '0, "R4");
   endtask

   task automatic t_load();
      run(3'd4, mk(2, 8'h05), '0, '0, mk(7, 8'hFF), '0, "R5");
      // fails only on a compartment bit
      run(3'd4, mk(2, 8'h05), '0, '0, mk(7, 8'h04), '0, "R5");
      // fails only on level
      run(3'd4, mk(6, 8'h01), '0, '0, mk(5, 8'hFF), '0, "R9");
   endtask

   task automatic t_channels();
      run(3'd5, '0, '0, '0, mk(4, 8'h0F), mk(3, 8'h09), "R6");
      run(3'd5, '0, '0, '0, mk(4, 8'h0F), mk(3, 8'h19), "R6");
      run(3'd6, mk(1, 8'h02), '0, '0, '0, mk(1, 8'h03), "R7");
      run(3'd6, mk(2, 8'h02), '0, '0, '0, mk(1, 8'h03), "R7");
   endtask

   task automatic t_stack();
      int lvl = 0;
      while (m_cnt < DEPTH) begin
         run(3'd2, mk(lvl % 8, 1 << (lvl % 8)), '0, '0, '0, '0, "R8");
         lvl++;
      end
      run(3'd2, mk(7, 8'hAA), '0, '0, '0, '0, "R8");
      while (m_cnt > 0) run(3'd3, '0, '0, '0, '0, '0, "R4");
      run(3'd3, '0, '0, '0, '0, '0, "R8");
   endtask

   task automatic t_reserved();
      run(3'd7, mk(1, 8'h01), '0, mk(3, 8'h00), '0, '0, "R11");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_compute();
      t_idle();
      t_nested();
      t_load();
      t_channels();
      t_stack();
      t_reserved();
      t_idle();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule